// File: doc/BRIEF.md
# Group-wise INT4 to FP16 Weight Dequantizer

This block sits directly in front of a matrix-multiply array and expands packed 4-bit quantized weights into FP16 values on the fly. Weights arrive as 32-bit words of eight signed nibbles, already laid out in the array's native tile order. Scales arrive separately as 128-bit words, each carrying the eight FP16 scales of one super-group of eight quantization groups, so a single aligned transfer covers 256 weights.

Each nibble is turned into an exact FP16 integer by indexing a 16-entry table, then multiplied by the scale of its group with round-to-nearest-even. Groups span 32 consecutive weights (four input words), so the scale in use only changes on a tile boundary. Results leave one per cycle on a valid/ready stream; when the consumer stalls, both input streams stall with it, and nothing is lost or repeated.

Top module: `grp_dequant`

## Requirements
- R1: Nibble codes are two's complement (-8 to +7); with a scale of 1.0 (0x3C00) each code yields the exact FP16 encoding of its integer, e.g. 7 gives 0x4700 and -8 gives 0xC800.
- R2: Within a weight word, nibble bits [3:0] are emitted first and bits [31:28] last; words are emitted in arrival order with no reordering.
- R3: The k-th weight word since reset, counted modulo 32, uses scale field g = (k mod 32) / 4, located at bits [16g+15:16g] of the current scale word.
- R4: After 256 outputs from one scale word, no further output appears until a new scale word has been accepted; each scale word is accepted exactly once per 256 weights.
- R5: For normal scales the code-times-scale product is rounded to nearest, ties to even, into FP16.
- R6: A product beyond the FP16 range becomes signed infinity (0x7C00 / 0xFC00); a NaN scale gives 0x7E00; an infinite scale times a nonzero code gives signed infinity.
- R7: Code 0 gives 0x0000 whatever the scale; a zero or subnormal scale with a nonzero code gives zero carrying the XOR of the two signs; results below the smallest normal are flushed to signed zero.
- R8: While out_valid is high and out_ready low, out_valid stays high and out_data holds its value; every weight produces exactly one output.
- R9: After reset out_valid is 0, wt_ready and sc_ready are 1, and the nibble and word counters restart at zero; a held weight word produces no output until a scale word arrives.
- R10: With out_ready held high and both inputs continuously offered, one output is produced every cycle, including across word and super-group boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wt_valid_i | input | 1 | Weight word offered |
| wt_ready_o | output | 1 | Weight word taken on this edge when valid |
| wt_data_i | input | 32 | Eight packed signed 4-bit codes, lowest nibble first |
| sc_valid_i | input | 1 | Scale word offered |
| sc_ready_o | output | 1 | Scale word taken on this edge when valid |
| sc_data_i | input | 128 | Eight FP16 group scales, group 0 lowest |
| out_valid_o | output | 1 | Dequantized weight available |
| out_ready_i | input | 1 | Consumer accepts the output |
| out_data_o | output | 16 | FP16 dequantized weight |

## Verification
The busiest cycle is the one where the last nibble of the last word of a super-group is emitted: in that same edge the block must retire both the weight word and the scale bank, accept the next weight word and the next scale word, and do all of it only if the consumer is ready. The bench provokes this with continuous streams and an always-ready consumer, where any lost cycle shows up as a gap between first and last output, and again with a random consumer stall and random input gaps, where every value is compared in order against a model built from real arithmetic. A separate run withholds the second scale word, confirming that output stops after exactly 256 values and resumes with the new scales.

// File: rtl/dq_pkg.sv
package dq_pkg;

    typedef logic [15:0] fp16_t;

    // FP16 encoding of a signed 4-bit integer, evaluated at elaboration time
    function automatic fp16_t int4_to_fp16(input logic [3:0] code);
        int    v;
        int    mag;
        int    p;
        fp16_t h;
        v = code[3] ? int'(code) - 16 : int'(code);
        if (v == 0) return 16'h0000;
        mag = (v < 0) ? -v : v;
        p = 0;
        for (int b = 0; b < 4; b++) begin
            if (mag >= (1 << b)) p = b;
        end
        h[15]    = (v < 0);
        h[14:10] = 5'(15 + p);
        h[9:0]   = 10'((mag << (10 - p)) & 32'h3FF);
        return h;
    endfunction

endpackage

// File: rtl/dq_code_lut.sv
module dq_code_lut (
    input  logic [3:0]      code_i,
    output dq_pkg::fp16_t   fp_o
);
    localparam int ENTRIES = 16;

    dq_pkg::fp16_t rom [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        assign rom[i] = dq_pkg::int4_to_fp16(4'(i));
    end

    assign fp_o = rom[code_i];

endmodule

// File: rtl/dq_fp16_mul.sv
module dq_fp16_mul (
    input  dq_pkg::fp16_t a_i,       // code value, always normal unless a_zero_i
    input  logic          a_zero_i,
    input  dq_pkg::fp16_t b_i,       // group scale
    output dq_pkg::fp16_t p_o
);
    localparam logic [7:0] BIAS    = 8'd15;
    localparam logic [7:0] EXP_TOP = 8'd46;   // biased sum at which the result exponent reaches 31

    logic        sign;
    logic [21:0] prod;
    logic        hi;
    logic [9:0]  frac_t;
    logic        rnd;
    logic        stk;
    logic        inc;
    logic        carry;
    logic [9:0]  frac_r;
    logic [7:0]  esum;
    logic        b_max;
    logic        b_min;

    always_comb begin
        sign   = a_i[15] ^ b_i[15];
        prod   = {11'b0, 1'b1, a_i[9:0]} * {11'b0, 1'b1, b_i[9:0]};
        hi     = prod[21];
        frac_t = hi ? prod[20:11] : prod[19:10];
        rnd    = hi ? prod[10] : prod[9];
        stk    = hi ? (|prod[9:0]) : (|prod[8:0]);
        inc    = rnd & (stk | frac_t[0]);
        {carry, frac_r} = {1'b0, frac_t} + {10'b0, inc};
        esum   = {3'b0, a_i[14:10]} + {3'b0, b_i[14:10]} + {7'b0, hi} + {7'b0, carry};
        b_max  = (b_i[14:10] == 5'h1F);
        b_min  = (b_i[14:10] == 5'h00);

        if (a_zero_i) begin
            p_o = 16'h0000;
        end else if (b_max && (b_i[9:0] != 10'b0)) begin
            p_o = 16'h7E00;
        end else if (b_max) begin
            p_o = {sign, 5'h1F, 10'b0};
        end else if (b_min) begin
            p_o = {sign, 15'b0};
        end else if (esum >= EXP_TOP) begin
            p_o = {sign, 5'h1F, 10'b0};
        end else if (esum <= BIAS) begin
            p_o = {sign, 15'b0};
        end else begin
            p_o = {sign, 5'(esum - BIAS), frac_r};
        end
    end

endmodule

// File: rtl/dq_stream_ctrl.sv
module dq_stream_ctrl #(
    parameter int NIBS      = 8,
    parameter int WPG       = 4,
    parameter int SG_GROUPS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic wt_valid_i,
    input  logic sc_valid_i,
    input  logic adv_i,
    output logic wt_ready_o,
    output logic sc_ready_o,
    output logic produce_o,
    output logic [((NIBS > 1) ? $clog2(NIBS) : 1)-1:0]           nib_o,
    output logic [((SG_GROUPS > 1) ? $clog2(SG_GROUPS) : 1)-1:0] grp_o
);
    localparam int WPSG   = WPG * SG_GROUPS;
    localparam int NIB_IW = (NIBS > 1) ? $clog2(NIBS) : 1;
    localparam int GRP_IW = (SG_GROUPS > 1) ? $clog2(SG_GROUPS) : 1;
    localparam int CNT_W  = (WPSG > 1) ? $clog2(WPSG) : 1;
    localparam int WPG_SH = (WPG > 1) ? $clog2(WPG) : 0;

    typedef struct packed {
        logic              has_w;
        logic              has_s;
        logic [NIB_IW-1:0] nib;
        logic [CNT_W-1:0]  wcnt;
    } st_t;

    st_t  st_d, st_q;
    logic last_nib;
    logic last_word;
    logic retire_w;
    logic retire_s;
    logic take_w;
    logic take_s;

    always_comb begin
        st_d       = st_q;
        last_nib   = (st_q.nib == NIB_IW'(NIBS - 1));
        last_word  = (st_q.wcnt == CNT_W'(WPSG - 1));
        produce_o  = st_q.has_w && st_q.has_s && adv_i;
        retire_w   = produce_o && last_nib;
        retire_s   = retire_w && last_word;
        wt_ready_o = !st_q.has_w || retire_w;
        sc_ready_o = !st_q.has_s || retire_s;
        take_w     = wt_valid_i && wt_ready_o;
        take_s     = sc_valid_i && sc_ready_o;

        if (take_w)        st_d.has_w = 1'b1;
        else if (retire_w) st_d.has_w = 1'b0;
        if (take_s)        st_d.has_s = 1'b1;
        else if (retire_s) st_d.has_s = 1'b0;

        if (produce_o) st_d.nib = last_nib ? '0 : st_q.nib + 1'b1;
        if (retire_w)  st_d.wcnt = last_word ? '0 : st_q.wcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign nib_o = st_q.nib;
    assign grp_o = GRP_IW'(st_q.wcnt >> WPG_SH);

    // R2: after the last nibble of a word the next one starts at the bottom
    p_nib_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (produce_o && last_nib) |=> (st_q.nib == '0));

    // R3: finishing a word steps the word count by one inside a super-group
    p_word_step_r3: assert property (@(posedge clk) disable iff (rst)
        (produce_o && last_nib && !last_word) |=> (st_q.wcnt == $past(st_q.wcnt) + 1'b1));

    // R4: without a fresh scale word nothing is produced after a super-group ends
    p_scale_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (produce_o && last_nib && last_word && !sc_valid_i) |=> !produce_o);

endmodule

// File: rtl/grp_dequant.sv
module grp_dequant #(
    parameter int NIBS      = 8,
    parameter int GROUP_LEN = 32,
    parameter int SG_GROUPS = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wt_valid_i,
    output logic                    wt_ready_o,
    input  logic [4*NIBS-1:0]       wt_data_i,
    input  logic                    sc_valid_i,
    output logic                    sc_ready_o,
    input  logic [16*SG_GROUPS-1:0] sc_data_i,
    output logic                    out_valid_o,
    input  logic                    out_ready_i,
    output logic [15:0]             out_data_o
);
    localparam int W_W    = 4 * NIBS;
    localparam int S_W    = 16 * SG_GROUPS;
    localparam int WPG    = GROUP_LEN / NIBS;
    localparam int NIB_IW = (NIBS > 1) ? $clog2(NIBS) : 1;
    localparam int GRP_IW = (SG_GROUPS > 1) ? $clog2(SG_GROUPS) : 1;

    typedef struct packed {
        logic [W_W-1:0] word;
        logic [S_W-1:0] scales;
        logic           vld;
        logic [15:0]    dat;
    } dp_t;

    dp_t               dp_d, dp_q;
    logic              adv;
    logic              produce;
    logic [NIB_IW-1:0] nib_idx;
    logic [GRP_IW-1:0] grp_idx;
    logic [3:0]        cur_code;
    dq_pkg::fp16_t     cur_scale;
    dq_pkg::fp16_t     code_fp;
    dq_pkg::fp16_t     prod_fp;
    logic [3:0]        nib_arr [NIBS];
    dq_pkg::fp16_t     sc_arr  [SG_GROUPS];

    assign adv = !dp_q.vld || out_ready_i;

    dq_stream_ctrl #(
        .NIBS      (NIBS),
        .WPG       (WPG),
        .SG_GROUPS (SG_GROUPS)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wt_valid_i (wt_valid_i),
        .sc_valid_i (sc_valid_i),
        .adv_i      (adv),
        .wt_ready_o (wt_ready_o),
        .sc_ready_o (sc_ready_o),
        .produce_o  (produce),
        .nib_o      (nib_idx),
        .grp_o      (grp_idx)
    );

    for (genvar n = 0; n < NIBS; n++) begin : g_nib
        assign nib_arr[n] = dp_q.word[4*n +: 4];
    end

    for (genvar g = 0; g < SG_GROUPS; g++) begin : g_scale
        assign sc_arr[g] = dp_q.scales[16*g +: 16];
    end

    assign cur_code  = nib_arr[nib_idx];
    assign cur_scale = sc_arr[grp_idx];

    dq_code_lut u_lut (
        .code_i (cur_code),
        .fp_o   (code_fp)
    );

    dq_fp16_mul u_mul (
        .a_i      (code_fp),
        .a_zero_i (cur_code == 4'h0),
        .b_i      (cur_scale),
        .p_o      (prod_fp)
    );

    always_comb begin
        dp_d = dp_q;
        if (wt_valid_i && wt_ready_o) dp_d.word   = wt_data_i;
        if (sc_valid_i && sc_ready_o) dp_d.scales = sc_data_i;
        if (adv)     dp_d.vld = produce;
        if (produce) dp_d.dat = prod_fp;
    end

    always_ff @(posedge clk) begin
        if (rst) dp_q <= '0;
        else     dp_q <= dp_d;
    end

    assign out_valid_o = dp_q.vld;
    assign out_data_o  = dp_q.dat;

    // R8: a stalled output neither drops nor changes
    p_hold_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    // R7: a zero code always leaves as positive zero
    p_zero_code_r7: assert property (@(posedge clk) disable iff (rst)
        (produce && cur_code == 4'h0) |=> (out_data_o == 16'h0000));

    // R9: reset empties the output stage
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> !out_valid_o);

endmodule

// File: tb/grp_dequant_bench.sv
`timescale 1ns/100ps
module grp_dequant_bench;

    localparam int NIBS     = 8;
    localparam int WPSG     = 32;
    localparam int SG_OUTS  = 256;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wt_valid = 1'b0;
    logic         wt_ready;
    logic [31:0]  wt_data = '0;
    logic         sc_valid = 1'b0;
    logic         sc_ready;
    logic [127:0] sc_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [15:0]  out_data;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int rx_count = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [31:0]  w_arr [$];
    logic [127:0] s_arr [$];
    logic [15:0]  expq  [$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    grp_dequant u_grp_dequant (
        .clk         (clk),
        .rst         (rst),
        .wt_valid_i  (wt_valid),
        .wt_ready_o  (wt_ready),
        .wt_data_i   (wt_data),
        .sc_valid_i  (sc_valid),
        .sc_ready_o  (sc_ready),
        .sc_data_i   (sc_data),
        .out_valid_o (out_valid),
        .out_ready_i (out_ready),
        .out_data_o  (out_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit coin();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    function automatic real pow2(input int n);
        real r = 1.0;
        if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
        else        for (int i = 0; i < -n; i++) r = r / 2.0;
        return r;
    endfunction

    // independent model: exact real product, then RNE into FP16
    function automatic logic [15:0] ref_mul(input logic [3:0] code, input logic [15:0] sc);
        int  cv;
        int  e;
        int  r;
        real x;
        real y;
        real fl;
        bit  neg;
        cv = code[3] ? int'(code) - 16 : int'(code);
        if (cv == 0) return 16'h0000;
        neg = (cv < 0) ^ sc[15];
        if (sc[14:10] == 5'h1F) return (sc[9:0] != 0) ? 16'h7E00 : {neg, 15'h7C00};
        if (sc[14:10] == 5'h00) return {neg, 15'h0};
        x = real'((cv < 0) ? -cv : cv) * (1.0 + real'(sc[9:0]) / 1024.0)
            * pow2(int'(sc[14:10]) - 15);
        e = 0;
        while (x >= 2.0) begin x = x / 2.0; e++; end
        while (x < 1.0)  begin x = x * 2.0; e--; end
        y  = x * 1024.0;
        fl = $floor(y);
        r  = int'(fl);
        if ((y - fl) > 0.5 || ((y - fl) == 0.5 && (r % 2) == 1)) r++;
        if (r == 2048) begin r = 1024; e++; end
        if (e > 15)  return {neg, 15'h7C00};
        if (e < -14) return {neg, 15'h0};
        return {neg, 5'(e + 15), 10'(r - 1024)};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wt_valid = 1'b0; sc_valid = 1'b0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic feed_w(input bit gaps);
        for (int k = 0; k < w_arr.size(); k++) begin
            @(negedge clk);
            if (gaps) while (coin()) begin wt_valid = 1'b0; @(negedge clk); end
            wt_valid = 1'b1; wt_data = w_arr[k];
            #1;
            while (!wt_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        wt_valid = 1'b0;
    endtask

    task automatic feed_s(input bit gaps, input bit hold);
        for (int j = 0; j < s_arr.size(); j++) begin
            @(negedge clk);
            sc_valid = 1'b0;
            if (hold && j > 0) begin
                while (rx_count < j * SG_OUTS) @(negedge clk);
                repeat (20) @(negedge clk);
                #1;
                // R4: output halts at the super-group edge until the scale word comes
                check(rx_count == j * SG_OUTS && !out_valid, "R4", "stall at super-group edge",
                      rx_count, j * SG_OUTS);
                @(negedge clk);
            end
            if (gaps) while (coin()) begin sc_valid = 1'b0; @(negedge clk); end
            sc_valid = 1'b1; sc_data = s_arr[j];
            #1;
            while (!sc_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        sc_valid = 1'b0;
    endtask

    task automatic collect(input int total, input bit rand_rdy, input bit tp, input string tag);
        int   rx = 0;
        int   first_c = 0;
        int   last_c = 0;
        bit   stalled = 1'b0;
        logic [15:0] held = '0;
        while (rx < total) begin
            @(negedge clk);
            out_ready = rand_rdy ? coin() : 1'b1;
            #1;
            // R8: stalled output stays valid and unchanged
            if (stalled) check(out_valid && out_data == held, "R8", "hold under stall",
                               out_data, held);
            if (out_valid && out_ready) begin
                check(out_data == expq[rx], tag, $sformatf("output %0d", rx), out_data, expq[rx]);
                if (rx == 0) first_c = cyc;
                last_c = cyc;
                rx++;
                rx_count = rx;
            end
            stalled = out_valid && !out_ready;
            held    = out_data;
        end
        @(negedge clk);
        out_ready = 1'b1;
        repeat (6) @(negedge clk);
        #1;
        // R8: no duplicate values after the stream drains
        check(!out_valid, "R8", "no extra output", out_valid, 0);
        // R10: one value per cycle without stalls
        if (tp) check(last_c - first_c == total - 1, "R10", "cycles first to last",
                      last_c - first_c, total - 1);
    endtask

    task automatic run(input bit rand_rdy, input bit gaps, input bit hold,
                       input bit tp, input string tag);
        int total;
        expq.delete();
        rx_count = 0;
        for (int k = 0; k < w_arr.size(); k++)
            for (int j = 0; j < NIBS; j++)
                expq.push_back(ref_mul(w_arr[k][4*j +: 4],
                               s_arr[k / WPSG][16*((k % WPSG) / 4) +: 16]));
        total = w_arr.size() * NIBS;
        fork
            feed_w(gaps);
            feed_s(gaps, hold);
            collect(total, rand_rdy, tp, tag);
        join
    endtask

    function automatic logic [127:0] pack_scales(input logic [15:0] v [8]);
        logic [127:0] s;
        for (int g = 0; g < 8; g++) s[16*g +: 16] = v[g];
        return s;
    endfunction

    task automatic t_reset();
        do_reset();
        #1;
        check(!out_valid, "R9", "out_valid after reset", out_valid, 0);
        check(wt_ready, "R9", "wt_ready after reset", wt_ready, 1);
        check(sc_ready, "R9", "sc_ready after reset", sc_ready, 1);
        @(negedge clk);
        wt_valid = 1'b1; wt_data = 32'h1234_5671;
        out_ready = 1'b1;
        repeat (10) @(negedge clk);
        #1;
        check(!out_valid, "R9", "no output without scale", out_valid, 0);
        check(!wt_ready, "R9", "word held while waiting", wt_ready, 0);
        @(negedge clk);
        wt_valid = 1'b0;
    endtask

    task automatic t_lut();
        logic [15:0] v [8];
        do_reset();
        for (int g = 0; g < 8; g++) v[g] = 16'h3C00;
        w_arr.delete(); s_arr.delete();
        w_arr.push_back(32'h7654_3210);
        w_arr.push_back(32'hFEDC_BA98);
        s_arr.push_back(pack_scales(v));
        // R1 R2: table values in nibble order; 7 -> 0x4700, -8 -> 0xC800
        run(1'b0, 1'b0, 1'b0, 1'b0, "R1 R2");
    endtask

    task automatic t_groups();
        logic [15:0] v [8];
        do_reset();
        w_arr.delete(); s_arr.delete();
        for (int k = 0; k < 64; k++) w_arr.push_back((32'h9E37_79B9 * (k + 1)) ^ k);
        for (int j = 0; j < 2; j++) begin
            for (int g = 0; g < 8; g++) v[g] = {1'(g % 2), 5'(13 + g), 10'(97 * j + 31 * g)};
            s_arr.push_back(pack_scales(v));
        end
        // R3: group scale selection; R10 throughput on the same run
        run(1'b0, 1'b0, 1'b0, 1'b1, "R3");
    endtask

    task automatic t_backpressure();
        logic [15:0] v [8];
        do_reset();
        w_arr.delete(); s_arr.delete();
        for (int k = 0; k < 48; k++) w_arr.push_back((32'h85EB_CA6B * (k + 3)) ^ (k << 7));
        for (int j = 0; j < 2; j++) begin
            for (int g = 0; g < 8; g++) v[g] = {1'(j), 5'(9 + 2 * g), 10'(211 * g + 13 * j)};
            s_arr.push_back(pack_scales(v));
        end
        run(1'b1, 1'b1, 1'b0, 1'b0, "R8");
    endtask

    task automatic t_arith();
        logic [15:0] v [8];
        do_reset();
        w_arr.delete(); s_arr.delete();
        for (int k = 0; k < 32; k++) w_arr.push_back((k % 2) ? 32'hFEDC_BA98 : 32'h7654_3210);
        v[0] = 16'h3C01;  // ties for rounding
        v[1] = 16'h7BFF;  // overflow
        v[2] = 16'hBC00;  // negative scale with zero codes
        v[3] = 16'h8000;  // negative zero scale
        v[4] = 16'h0200;  // subnormal scale
        v[5] = 16'h7E01;  // NaN scale
        v[6] = 16'hFC00;  // negative infinity scale
        v[7] = 16'h3555;  // inexact rounding
        s_arr.push_back(pack_scales(v));
        run(1'b0, 1'b0, 1'b0, 1'b0, "R5 R6 R7");
    endtask

    task automatic t_sg_stall();
        logic [15:0] v [8];
        do_reset();
        w_arr.delete(); s_arr.delete();
        for (int k = 0; k < 40; k++) w_arr.push_back((32'hC2B2_AE35 * (k + 5)) ^ k);
        for (int j = 0; j < 2; j++) begin
            for (int g = 0; g < 8; g++) v[g] = {1'b0, 5'(14 + j), 10'(64 * g + j)};
            s_arr.push_back(pack_scales(v));
        end
        // R4: second scale word withheld until the first 256 values are out
        run(1'b0, 1'b0, 1'b1, 1'b0, "R4");
    endtask

    initial begin
        t_reset();
        t_lut();
        t_groups();
        t_backpressure();
        t_arith();
        t_sg_stall();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule